// File: doc/BRIEF.md
# Saturating fixed-point multiply-minus-sum unit

This block evaluates `a*b - (a+b)` on two signed fixed-point operands and returns a narrower signed fixed-point result. Operand `a` is a 5-bit value with 2 fraction bits. Operand `b` is a 6-bit value with 3 fraction bits.

The block first moves both operands to a common 7-bit, 3-fraction-bit format and adds them there. It then widens that sum to the format of the full-precision product and subtracts. Finally it narrows the difference to a 7-bit, 4-fraction-bit output. The narrowing rounds toward positive infinity and clamps to the output range instead of wrapping.

A build-time option places a single output register after the arithmetic. The register loads only when the input strobe is high and has a synchronous reset. When the option is off, the block is purely combinational and the strobe passes straight through.

The block has no state machine. Its only sequential element is the optional output stage. That stage has two behaviours: it loads when the strobe is high and holds when the strobe is low.

Top module: `fxe_unit`

## Requirements
- R1: Operand `a` is read as a signed value in units of 2^-2 and operand `b` as a signed value in units of 2^-3. Before the addition, `a` is shifted left by one with sign extension, and both operands are extended to 7 bits. Their sum `s = 2a + b`, in units of 2^-3, is formed in 7 bits and never wraps for any inputs.
- R2: The product `a*b` is kept at full precision: 11 bits, in units of 2^-5. The sum is shifted left by two and sign-extended to 11 bits. The difference `d = a*b - 4s` is formed in units of 2^-5.
- R3: When `ceil(d/2)` lies in [-64, 63], `y` (two's complement, units of 2^-4) equals `ceil(d/2)`. This means an odd `d` rounds up.
- R4: When `ceil(d/2)` exceeds 63, `y` is 7'b0111111 (63). This includes `d = 127`, where rounding would otherwise wrap.
- R5: When `ceil(d/2)` is below -64, `y` is 7'b1000000 (-64).
- R6: With the output register built in (REG_OUT=1), `y` takes the R3–R5 result one clock after a cycle with `in_vld` high. After a cycle with `in_vld` low, `y` keeps its previous value.
- R7: With REG_OUT=1, `out_vld` equals the `in_vld` value of the previous clock cycle.
- R8: With REG_OUT=1, a cycle with `rst` high clears `y` and `out_vld` to zero on the next edge. This holds even when `in_vld` is high in that cycle.
- R9: With REG_OUT=0, `y` is the R3–R5 result of the current inputs, and `out_vld` equals `in_vld` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input strobe; acts as the load enable of the output register |
| a | input | 5 | Signed operand, 2 fraction bits |
| b | input | 6 | Signed operand, 3 fraction bits |
| y | output | 7 | Signed result, 4 fraction bits, rounded up and saturated |
| out_vld | output | 1 | Strobe aligned with `y` |

## Verification
The bench builds two copies of the block, both with the default operand and output formats.

One copy is built with REG_OUT=1 and one with REG_OUT=0. The combinational copy exposes the arithmetic of every input pair in the same cycle. The registered copy exposes the load, hold and reset behaviour of the output stage.

Because the default formats give only 2048 operand pairs, all of them are applied. This covers the saturation on both ends, the rounding of odd differences and the cases next to the positive clamp.

The strobe is dropped on a regular pattern during the sweep, so the registered copy is also seen holding its value.

// File: rtl/fxe_pkg.sv
package fxe_pkg;
    localparam int A_WIDTH = 5;
    localparam int A_FRAC  = 2;
    localparam int B_WIDTH = 6;
    localparam int B_FRAC  = 3;
    localparam int Y_WIDTH = 7;
    localparam int Y_FRAC  = 4;

    function automatic int imax(input int x, input int z);
        return (x > z) ? x : z;
    endfunction
endpackage

// File: rtl/fxe_align.sv
module fxe_align #(
    parameter int A_W = 5,
    parameter int A_F = 2,
    parameter int B_W = 6,
    parameter int B_F = 3,
    parameter int S_W = 7,
    parameter int S_F = 3
) (
    input  logic signed [A_W-1:0] a_i,
    input  logic signed [B_W-1:0] b_i,
    output logic signed [S_W-1:0] a_al,
    output logic signed [S_W-1:0] b_al
);
    localparam int SH_A = S_F - A_F;
    localparam int SH_B = S_F - B_F;

    logic signed [S_W-1:0] a_ext;
    logic signed [S_W-1:0] b_ext;

    always_comb begin
        a_ext = S_W'(a_i);
        b_ext = S_W'(b_i);
        a_al  = a_ext <<< SH_A;
        b_al  = b_ext <<< SH_B;
    end
endmodule

// File: rtl/fxe_arith.sv
module fxe_arith #(
    parameter int A_W = 5,
    parameter int B_W = 6,
    parameter int S_W = 7,
    parameter int S_F = 3,
    parameter int P_F = 5
) (
    input  logic signed [A_W-1:0]     a_i,
    input  logic signed [B_W-1:0]     b_i,
    input  logic signed [S_W-1:0]     a_al,
    input  logic signed [S_W-1:0]     b_al,
    output logic signed [A_W+B_W-1:0] diff_o
);
    localparam int P_W    = A_W + B_W;
    localparam int SUM_SH = P_F - S_F;

    logic signed [P_W-1:0] prod;
    logic signed [S_W-1:0] sum;
    logic signed [P_W-1:0] sum_wide;

    always_comb begin
        prod     = P_W'(a_i) * P_W'(b_i);
        sum      = a_al + b_al;
        sum_wide = P_W'(sum) <<< SUM_SH;
        diff_o   = prod - sum_wide;
    end
endmodule

// File: rtl/fxe_narrow.sv
module fxe_narrow #(
    parameter int D_W = 11,
    parameter int D_F = 5,
    parameter int Y_W = 7,
    parameter int Y_F = 4
) (
    input  logic signed [D_W-1:0] diff_i,
    output logic signed [Y_W-1:0] y_o
);
    localparam int SHIFT = D_F - Y_F;
    localparam int R_W   = D_W + 1;
    localparam logic signed [R_W-1:0] Y_MAX = R_W'((1 <<< (Y_W-1)) - 1);
    localparam logic signed [R_W-1:0] Y_MIN = R_W'(-(1 <<< (Y_W-1)));

    logic signed [R_W-1:0] flr;
    logic signed [R_W-1:0] rnd;
    logic                  frac_nz;

    always_comb begin
        flr     = R_W'(diff_i) >>> SHIFT;
        frac_nz = |diff_i[SHIFT-1:0];
        rnd     = flr + $signed({{(R_W-1){1'b0}}, frac_nz});
        if (rnd > Y_MAX) begin
            y_o = Y_MAX[Y_W-1:0];
        end else if (rnd < Y_MIN) begin
            y_o = Y_MIN[Y_W-1:0];
        end else begin
            y_o = rnd[Y_W-1:0];
        end
    end

    always_comb begin
        if (!$isunknown(diff_i)) begin
            if (diff_i >= 0) begin
                AST_SAT_HI: assert (!y_o[Y_W-1]); // R4
            end else begin
                AST_SAT_LO: assert (y_o[Y_W-1] || (y_o == '0)); // R5
            end
        end
    end
endmodule

// File: rtl/fxe_unit.sv
module fxe_unit
    import fxe_pkg::*;
#(
    parameter int A_W     = A_WIDTH,
    parameter int A_F     = A_FRAC,
    parameter int B_W     = B_WIDTH,
    parameter int B_F     = B_FRAC,
    parameter int Y_W     = Y_WIDTH,
    parameter int Y_F     = Y_FRAC,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    output logic signed [Y_W-1:0] y,
    output logic                 out_vld
);
    localparam int S_F = imax(A_F, B_F);
    localparam int S_W = imax(A_W + S_F - A_F, B_W + S_F - B_F) + 1;
    localparam int D_W = A_W + B_W;
    localparam int D_F = A_F + B_F;

    logic signed [S_W-1:0] a_al;
    logic signed [S_W-1:0] b_al;
    logic signed [D_W-1:0] diff;
    logic signed [Y_W-1:0] y_comb;

    fxe_align #(.A_W(A_W), .A_F(A_F), .B_W(B_W), .B_F(B_F), .S_W(S_W), .S_F(S_F)) u_align (
        .a_i(a), .b_i(b), .a_al(a_al), .b_al(b_al)
    );

    fxe_arith #(.A_W(A_W), .B_W(B_W), .S_W(S_W), .S_F(S_F), .P_F(D_F)) u_arith (
        .a_i(a), .b_i(b), .a_al(a_al), .b_al(b_al), .diff_o(diff)
    );

    fxe_narrow #(.D_W(D_W), .D_F(D_F), .Y_W(Y_W), .Y_F(Y_F)) u_narrow (
        .diff_i(diff), .y_o(y_comb)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic signed [Y_W-1:0] y_q;
            logic                  vld_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    y_q   <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_vld;
                    if (in_vld) begin
                        y_q <= y_comb;
                    end
                end
            end

            assign y       = y_q;
            assign out_vld = vld_q;

            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> $stable(y)); // R6
            AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
                in_vld |=> out_vld); // R7
            AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> !out_vld); // R7
            AST_RST_CLEAR: assert property (@(posedge clk)
                rst |=> ((y == '0) && !out_vld)); // R8
        end else begin : g_comb
            assign y       = y_comb;
            assign out_vld = in_vld;
        end
    endgenerate
endmodule

// File: tb/fxe_unit_bench.sv
module fxe_unit_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic signed [4:0] a = '0;
    logic signed [5:0] b = '0;
    logic signed [6:0] y_r;
    logic              vld_r;
    logic signed [6:0] y_c;
    logic              vld_c;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    int m_y = 0;
    bit m_v = 1'b0;

    always #2 clk = ~clk;

    fxe_unit #(.REG_OUT(1'b1)) u_fxe_unit (
        .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .y(y_r), .out_vld(vld_r)
    );

    fxe_unit #(.REG_OUT(1'b0)) u_fxe_unit_comb (
        .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .y(y_c), .out_vld(vld_c)
    );

    function automatic int unrounded(input int ai, input int bi);
        int s;
        s = 2 * ai + bi;
        return ai * bi - 4 * s;
    endfunction

    function automatic int model(input int ai, input int bi);
        int d;
        int r;
        d = unrounded(ai, bi);
        r = (d + 1) >>> 1;
        if (r > 63) r = 63;
        if (r < -64) r = -64;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_y <= 0;
            m_v <= 1'b0;
        end else begin
            m_v <= in_vld;
            if (in_vld) m_y <= model(int'(a), int'(b));
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", tag, a, b, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        in_vld = 1'b1;
        a = 5'sd7;
        b = 6'sd9;
        @(posedge clk);
        #1;
        chk("R8 reset y", int'(y_r), 0);
        chk("R8 reset out_vld", int'(vld_r), 0);
        rst = 1'b0;

        for (int i = 0; i < 2048; i++) begin
            int ai;
            int bi;
            int d;
            int e;
            ai = i / 64 - 16;
            bi = i % 64 - 32;
            a = 5'(ai);
            b = 6'(bi);
            in_vld = ((i % 5) != 3);
            #1;
            d = unrounded(ai, bi);
            e = model(ai, bi);
            if (((d + 1) >>> 1) > 63) chk("R4 positive clamp", int'(y_c), e);
            else if (((d + 1) >>> 1) < -64) chk("R5 negative clamp", int'(y_c), e);
            else chk("R1/R2/R3 rounded result", int'(y_c), e);
            chk("R9 comb strobe", int'(vld_c), int'(in_vld));
            @(posedge clk);
            #1;
            chk("R6 registered y", int'(y_r), m_y);
            chk("R7 registered out_vld", int'(vld_r), int'(m_v));
        end

        rst = 1'b1;
        in_vld = 1'b1;
        a = 5'sd15;
        b = 6'sd31;
        @(posedge clk);
        #1;
        chk("R8 mid-run reset y", int'(y_r), 0);
        chk("R8 mid-run reset out_vld", int'(vld_r), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule